// File: doc/BRIEF.md
# Serial Display Panel Link Controller

This controller sits on the host side of a three-wire link to a character display panel. The panel holds eight four-digit character modules and eight push buttons with built-in LEDs. One request names a 7-bit character code, the module to write (0 to 7), the digit within it (0 to 3) and an 8-bit LED pattern. The controller turns the request into a 25-bit control word, shifts it out on a data line with a slow clock, pulses a strobe to commit it, and then sends the same word again with every module write line released. The panel captures its button states on the strobe. After the last strobe the controller clocks the eight button bits back in and reorders them so that bit n of the result is button n.

A `start` pulse launches a request. `busy` covers the whole exchange and `done` marks the cycle in which the button byte becomes valid. The link clock runs at a rate set by a parameter: each high and each low phase lasts `DIV` system clocks.

Top module: `panel_link_ctrl`

## Requirements
- R1: Between one strobe and the next, and before the first strobe, the link clock gives exactly 25 rising edges. The word uses these bit positions: [3:0] write lines of modules 0-3, [7:4] LEDs 0-3, 8 char bit 3, 9 char bit 2, 10 char bit 1, 11 char bit 0, [15:12] LEDs 4-7, 16 char bit 5, 17 char bit 4, 18 digit bit 1, 19 digit bit 0, [23:20] write lines of modules 4-7, 24 char bit 6.
- R2: Word bit 24 is sent first, then bits 23 down to 0, one bit per rising edge.
- R3: In the first word of a request, the write line of the selected module is 0 and the other seven are 1.
- R4: Each LED bit of the word is the inverse of the matching bit of the requested pattern.
- R5: A second word follows the first. It has all eight write lines at 1 and every other field unchanged, and it is committed by a second strobe.
- R6: The link clock idles low. Data changes only while the clock is low. Every high phase of the clock lasts exactly `DIV` system clocks.
- R7: The strobe is raised only while the link clock is low, and it is never high while idle.
- R8: The first button bit is sampled after the last strobe falls and before any read clock. Seven more bits follow, one after each further rising edge. The arrival order is buttons 4,3,2,1,7,6,5,0, and `buttons[n]` reports button n.
- R9: `busy` rises on the cycle after an accepted `start` and stays high until `done`. `done` is high for exactly one cycle, with `busy` low and `buttons` valid.
- R10: A `start` pulse while `busy` is high is ignored: no extra words or strobes result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a request (taken while idle) |
| char_code | input | 7 | Character code to write |
| module_sel | input | 3 | Module to write |
| digit_sel | input | 2 | Digit within the module |
| led_pattern | input | 8 | LED pattern, 1 = lit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| buttons | output | 8 | Button states indexed by button number |
| ser_data | output | 1 | Serial data to the panel |
| ser_clk | output | 1 | Link clock to the panel |
| ser_strobe | output | 1 | Commit strobe to the panel |
| btn_in | input | 1 | Serial button data from the panel |

## Verification
The checks on the link wires assume that `btn_in` changes only in reaction to the link clock or strobe, and never in the system-clock cycle in which the controller samples it. The bench's panel model changes the returned bit only on a link clock rising edge or a strobe rising edge, so that condition always holds. The assertions also assume that request fields are sampled only when `start` is accepted. The bench changes those fields and pulses `start` mid-exchange to show that nothing else reads them.

// File: rtl/panel_link_ctrl.sv
module panel_link_ctrl #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] char_code,
  input  logic [2:0] module_sel,
  input  logic [1:0] digit_sel,
  input  logic [7:0] led_pattern,
  output logic       busy,
  output logic       done,
  output logic [7:0] buttons,
  output logic       ser_data,
  output logic       ser_clk,
  output logic       ser_strobe,
  input  logic       btn_in
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int WBITS = 25;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STROBE, S_READ} st_t;

  st_t         st;
  logic [CW-1:0] divc;
  logic        ph, pass;
  logic [4:0]  idx;
  logic [6:0]  ch_q;
  logic [2:0]  mod_q;
  logic [1:0]  dig_q;
  logic [7:0]  led_q, wr, rxf;
  logic [6:0]  rx;
  logic [WBITS-1:0] word;

  wire tick = (divc == CW'(DIV - 1));

  assign wr = pass ? 8'hFF : ~(8'b1 << mod_q);
  assign word = {ch_q[6], wr[7:4], dig_q[0], dig_q[1], ch_q[4], ch_q[5],
                 ~led_q[7:4], ch_q[0], ch_q[1], ch_q[2], ch_q[3],
                 ~led_q[3:0], wr[3:0]};
  assign rxf = {btn_in, rx};

  assign busy       = (st != S_IDLE);
  assign ser_clk    = ph && (st == S_SHIFT || st == S_READ);
  assign ser_strobe = (st == S_STROBE) && !ph;
  assign ser_data   = (st == S_SHIFT) ? word[idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; divc <= '0; ph <= 1'b0; pass <= 1'b0; idx <= '0;
      rx <= '0; buttons <= '0; done <= 1'b0;
      ch_q <= '0; mod_q <= '0; dig_q <= '0; led_q <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          ch_q <= char_code; mod_q <= module_sel;
          dig_q <= digit_sel; led_q <= led_pattern;
          st <= S_SHIFT; pass <= 1'b0; idx <= 5'(WBITS - 1);
          ph <= 1'b0; divc <= '0;
        end
      end else begin
        divc <= tick ? '0 : divc + 1'b1;
        if (tick) begin
          if (!ph) ph <= 1'b1;
          else begin
            ph <= 1'b0;
            case (st)
              S_SHIFT:
                if (idx == 0) st <= S_STROBE;
                else idx <= idx - 1'b1;
              S_STROBE:
                if (!pass) begin
                  pass <= 1'b1; idx <= 5'(WBITS - 1); st <= S_SHIFT;
                end else begin
                  st <= S_READ; rx <= {6'b0, btn_in}; idx <= 5'd1;
                end
              S_READ:
                if (idx == 5'd7) begin
                  st <= S_IDLE; done <= 1'b1;
                  buttons <= {rxf[4], rxf[5], rxf[6], rxf[0],
                              rxf[1], rxf[2], rxf[3], rxf[7]};
                end else begin
                  rx[idx[2:0]] <= btn_in;
                  idx <= idx + 1'b1;
                end
              default: st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/panel_link_ctrl_chk.sv
module panel_link_ctrl_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_strobe
);
  logic [31:0] hcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hcnt <= '0;
    else if (ser_clk) hcnt <= hcnt + 1;
    else hcnt <= '0;
  end

  a_r6_data_moves_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ser_data) |-> !ser_clk);
  a_r6_clk_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hcnt == 32'(DIV));
  a_r7_strobe_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    ser_strobe |-> !ser_clk);
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_strobe && !ser_data));
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind panel_link_ctrl panel_link_ctrl_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ser_data(ser_data), .ser_clk(ser_clk), .ser_strobe(ser_strobe));

// File: tb/panel_link_ctrl_test.sv
module panel_link_ctrl_test;
  localparam int TCLK = 10;
  localparam int DIVT = 3;

  logic clk = 0, rst_n = 0, start = 0, btn_in;
  logic [6:0] char_code = 0;
  logic [2:0] module_sel = 0;
  logic [1:0] digit_sel = 0;
  logic [7:0] led_pattern = 0;
  logic busy, done, ser_data, ser_clk, ser_strobe;
  logic [7:0] buttons;

  panel_link_ctrl #(.DIV(DIVT)) uut (.*);

  always #(TCLK/2) clk = ~clk;

  int checks = 0, fails = 0, nclk = 0, hw = 0;
  logic [24:0] cap = 0;
  logic [7:0] psr = 0, pbtn = 0;
  logic [24:0] wq[$];
  logic [7:0] bq[$];
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] mkword(input logic [6:0] c, input logic [2:0] m,
      input logic [1:0] d, input logic [7:0] l, input bit second);
    logic [24:0] w;
    logic [7:0] wl;
    wl = 8'hFF;
    if (!second) wl[m] = 1'b0;
    w[3:0] = wl[3:0];     w[23:20] = wl[7:4];
    w[7:4] = ~l[3:0];     w[15:12] = ~l[7:4];
    w[8] = c[3]; w[9] = c[2]; w[10] = c[1]; w[11] = c[0];
    w[16] = c[5]; w[17] = c[4]; w[18] = d[1]; w[19] = d[0]; w[24] = c[6];
    return w;
  endfunction

  assign btn_in = psr[7];

  always @(posedge ser_clk) begin
    cap <= {cap[23:0], ser_data};
    nclk++;
    if (!ser_strobe) psr <= {psr[6:0], 1'b0};
  end

  always @(posedge ser_strobe) begin
    chk(nclk == 25, "R1 clock edges per strobe", nclk, 25);
    if (wq.size() == 0) chk(0, "R10 unexpected strobe", 0, 0);
    else begin
      logic [24:0] e;
      e = wq.pop_front();
      chk(cap == e, "R2 R3 R4 R5 word content", cap, e);
    end
    psr <= {pbtn[4], pbtn[3], pbtn[2], pbtn[1], pbtn[7], pbtn[6], pbtn[5], pbtn[0]};
    nclk = 0;
  end

  always @(negedge clk) begin
    if (ser_clk) hw++;
    else if (hw != 0) begin
      chk(hw == DIVT, "R6 clock high width", hw, DIVT);
      hw = 0;
    end
    if (done) begin
      chk(!busy, "R9 busy low at done", busy, 0);
      if (bq.size() == 0) chk(0, "R10 unexpected done", 0, 0);
      else begin
        logic [7:0] e;
        e = bq.pop_front();
        chk(buttons == e, "R8 button remap", buttons, e);
      end
    end
  end

  task automatic send(input logic [6:0] c, input logic [2:0] m, input logic [1:0] d,
      input logic [7:0] l, input logic [7:0] b, input bit poke);
    pbtn = b;
    wq.push_back(mkword(c, m, d, l, 0));
    wq.push_back(mkword(c, m, d, l, 1));
    bq.push_back(b);
    @(negedge clk);
    char_code = c; module_sel = m; digit_sel = d; led_pattern = l;
    start = 1; nclk = 0;
    @(negedge clk);
    start = 0;
    chk(busy, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      char_code = ~c; module_sel = m + 3'd1; digit_sel = ~d; led_pattern = ~l;
      start = 1;
      @(negedge clk);
      start = 0;
      repeat (200) @(negedge clk);
      char_code = ~c; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle", {done, busy}, 0);
  endtask

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !ser_clk && !ser_strobe && !ser_data && buttons == 0,
        "R7 R9 reset state", {busy, done, ser_clk, ser_strobe, ser_data, buttons}, 0);
    send(7'h41, 3'd0, 2'd0, 8'h00, 8'h01, 0);
    send(7'h7F, 3'd7, 2'd3, 8'hFF, 8'h80, 0);
    send(7'h2A, 3'd4, 2'd1, 8'hA5, 8'h3C, 0);
    send(7'h55, 3'd3, 2'd2, 8'h0F, 8'hF0, 0);
    send(7'h00, 3'd5, 2'd2, 8'h81, 8'h5A, 1);
    for (int i = 0; i < 8; i++)
      send(7'(8'h30 + i), 3'(i), 2'(i), 8'(1 << i), 8'(1 << i), 0);
    repeat (300) @(negedge clk);
    chk(wq.size() == 0 && bq.size() == 0, "R10 no extra exchanges", wq.size(), 0);
    chk(!ser_clk && !ser_strobe, "R6 link idles low", {ser_clk, ser_strobe}, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule